// File: doc/BRIEF.md
# Two-Wire Serial Command Slave with Busy Handshake

This block is the slave end of a two-wire synchronous serial link. The master supplies the serial clock and shares a single data line with the slave. The slave receives a 16-bit command word, most significant bit first, and passes it to the local processing logic with a one-cycle strobe. From then on it owns the data line. It holds the line high while the local side is working. Once the local side presents a response, the slave pulls the line low for a fixed interval, which tells the master it may read. It then shifts the 16-bit response out, most significant bit first, and releases the line.

Both serial inputs pass through a two-flop synchronizer and are sampled in the system clock domain. The slave changes its outgoing data after a falling clock edge and samples incoming data on a rising edge. The low interval is a counter, and its length comes from the system clock frequency and the interval in microseconds. The data line appears as a separate data-out and output-enable pair. Only one command is outstanding at a time, and each command gets exactly one response.

Top module: `twowire_cmd_slave`

## Requirements
- R1: While reset is asserted and immediately after it, `sda_oe` and `cmd_valid` are 0 and `cmd_data` is 0.
- R2: In the receive state, each synchronized rising edge of `sck_i` shifts in one bit of `sda_i`, MSb first. After the 16th rising edge, `cmd_valid` is high for exactly one cycle and `cmd_data` holds the received word.
- R3: From the cycle in which `cmd_valid` is high until `rsp_valid` is sampled, `sda_oe` and `sda_o` are both 1.
- R4: An `rsp_valid` pulse while the block is receiving has no effect, and `sda_oe` stays 0.
- R5: After `rsp_valid` is sampled in the busy phase, `sda_oe` is 1 and `sda_o` is 0 for exactly CLK_HZ/1e6 × READY_US system cycles (1500 by default). In the next cycle `sda_o` carries bit 15 of the response.
- R6: During the response, each synchronized falling edge of `sck_i` advances `sda_o` to the next lower bit. A master that samples on its rising edges reads `rsp_data` MSb first.
- R7: After the 16th rising edge of the response, `sda_oe` drops to 0 and the block receives the next command.
- R8: Serial clock edges during the busy phase are ignored. They produce no `cmd_valid`, and the line stays driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| sda_i | input | 1 | Data line as seen at the pin |
| sda_o | output | 1 | Value the slave drives onto the data line |
| sda_oe | output | 1 | High while the slave drives the data line |
| cmd_valid | output | 1 | One-cycle strobe when a command word is complete |
| cmd_data | output | 16 | Last received command word |
| rsp_valid | input | 1 | Local side has a response; ends the busy phase |
| rsp_data | input | 16 | Response word, sampled with `rsp_valid` |

## Verification
The assertions assume that the master starts a new command only after the previous response has been read. They also assume that `rsp_valid` is raised only for a command that is pending, and that each serial clock level lasts longer than the three-flop synchronizer and edge-detect path. The stimulus holds each serial clock level for six system cycles and changes data only while the serial clock is low. It waits for the low pulse before clocking out the response. Stray `rsp_valid` pulses and serial clock edges are sent only in the phases where the requirements say they must be ignored.

// File: rtl/twowire_cmd_slave.sv
module twowire_cmd_slave #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int READY_US = 15,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_data,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data
);
  localparam int READY_CYC = (CLK_HZ / 1_000_000) * READY_US;
  localparam int CNT_W     = $clog2(READY_CYC + 1);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam logic [1:0] ST_RX = 2'd0, ST_BUSY = 2'd1, ST_LOW = 2'd2, ST_TX = 2'd3;

  logic [1:0]        state;
  logic [2:0]        sck_q;
  logic [1:0]        sda_q;
  logic [WORD_W-2:0] rx_sh;
  logic [WORD_W-1:0] tx_sh;
  logic [BIT_W-1:0]  bits;
  logic [CNT_W-1:0]  cnt;

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire last_bit = (bits == BIT_W'(WORD_W - 1));

  assign sda_oe = (state != ST_RX);
  assign sda_o  = (state == ST_BUSY) | ((state == ST_TX) & tx_sh[WORD_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sda_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck_i};
      sda_q <= {sda_q[0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RX;
      rx_sh     <= '0;
      tx_sh     <= '0;
      bits      <= '0;
      cnt       <= '0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      case (state)
        ST_RX: if (sck_rise) begin
          rx_sh <= {rx_sh[WORD_W-3:0], sda_q[1]};
          if (last_bit) begin
            bits      <= '0;
            cmd_data  <= {rx_sh, sda_q[1]};
            cmd_valid <= 1'b1;
            state     <= ST_BUSY;
          end else begin
            bits <= bits + 1'b1;
          end
        end
        ST_BUSY: if (rsp_valid) begin
          tx_sh <= rsp_data;
          cnt   <= CNT_W'(READY_CYC - 1);
          state <= ST_LOW;
        end
        ST_LOW: begin
          if (cnt == '0) begin
            bits  <= '0;
            state <= ST_TX;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (sck_fall) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
          if (sck_rise) begin
            if (last_bit) begin
              bits  <= '0;
              state <= ST_RX;
            end else begin
              bits <= bits + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/twowire_cmd_slave_chk.sv
module twowire_cmd_slave_chk #(
  parameter int READY_CYC = 1500
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       sda_o,
  input logic       sda_oe,
  input logic       cmd_valid,
  input logic       rsp_valid
);
  localparam logic [1:0] ST_RX = 2'd0, ST_BUSY = 2'd1, ST_LOW = 2'd2;

  logic [31:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_len <= '0;
    else        low_len <= (state == ST_LOW) ? low_len + 1 : '0;
  end

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r3_line_high_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (sda_oe && sda_o));
  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && !rsp_valid) |=> (state == ST_BUSY && sda_oe && sda_o));
  a_r4_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX) |-> !sda_oe);
  a_r5_low_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOW) |-> (sda_oe && !sda_o));
  a_r5_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    (low_len != 0 && state != ST_LOW) |-> (low_len == READY_CYC));
  a_r8_cmd_only_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ($past(state) == ST_RX));
endmodule

bind twowire_cmd_slave twowire_cmd_slave_chk #(.READY_CYC(READY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .sda_o(sda_o), .sda_oe(sda_oe),
  .cmd_valid(cmd_valid), .rsp_valid(rsp_valid)
);

// File: tb/twowire_cmd_slave_tb.sv
`timescale 1ns/1ps
module twowire_cmd_slave_tb;
  localparam int CLK_HZ = 100_000_000;
  localparam int READY_US = 15;
  localparam int RC = (CLK_HZ / 1_000_000) * READY_US;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, m_sck = 0, m_sda = 0, rsp_valid = 0;
  logic [15:0] rsp_data = '0;
  logic sda_o, sda_oe, cmd_valid;
  logic [15:0] cmd_data;
  int checks = 0, errors = 0;
  bit done = 0;
  bit seen = 0;
  logic [15:0] seen_data;

  always #5 clk = ~clk;

  twowire_cmd_slave #(.CLK_HZ(CLK_HZ), .READY_US(READY_US), .WORD_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(m_sck), .sda_i(m_sda), .sda_o(sda_o),
    .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  int sh[4], dh[4];
  int mode, mbits, mcnt;
  logic [15:0] mrx, mtx, mcmd;
  logic mvalid;

  task automatic model_step();
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin sh[i] = 0; dh[i] = 0; end
      mode = 0; mbits = 0; mcnt = 0; mrx = 0; mtx = 0; mcmd = 0; mvalid = 0;
    end else begin
      bit rise, fall;
      for (int i = 3; i > 0; i--) begin sh[i] = sh[i-1]; dh[i] = dh[i-1]; end
      sh[0] = int'(m_sck); dh[0] = int'(m_sda);
      rise = (sh[2] == 1) && (sh[3] == 0);
      fall = (sh[2] == 0) && (sh[3] == 1);
      mvalid = 0;
      case (mode)
        0: if (rise) begin
          mrx = {mrx[14:0], dh[2][0]};
          mbits++;
          if (mbits == 16) begin mbits = 0; mcmd = mrx; mvalid = 1; mode = 1; end
        end
        1: if (rsp_valid) begin mtx = rsp_data; mcnt = RC; mode = 2; end
        2: begin mcnt--; if (mcnt == 0) begin mbits = 0; mode = 3; end end
        default: begin
          if (fall) mtx = {mtx[14:0], 1'b0};
          if (rise) begin mbits++; if (mbits == 16) begin mbits = 0; mode = 0; end end
        end
      endcase
    end
  endtask

  task automatic cmp();
    logic eoe, eo;
    eoe = (mode != 0);
    eo = (mode == 1) || (mode == 3 && mtx[15]);
    checks++;
    if (sda_oe !== eoe || sda_o !== eo || cmd_valid !== mvalid || cmd_data !== mcmd) begin
      errors++;
      $display("FAIL R3 R5 R6 cycle model: oe=%0b o=%0b v=%0b d=%h expected oe=%0b o=%0b v=%0b d=%h",
               sda_oe, sda_o, cmd_valid, cmd_data, eoe, eo, mvalid, mcmd);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    model_step();
    cmp();
    if (cmd_valid) begin seen = 1; seen_data = cmd_data; end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      m_sda = w[i];
      repeat (HALF) tick();
      m_sck = 1;
      repeat (HALF) tick();
      m_sck = 0;
    end
    m_sda = 0;
  endtask

  task automatic transact(input logic [15:0] c, input logic [15:0] r, input bit stray);
    int bad;
    logic [15:0] got;
    seen = 0;
    send(c);
    repeat (8) tick();
    check(seen && seen_data == c, "R2 command word", int'(seen_data), int'(c));
    check(sda_oe && sda_o, "R3 busy high", int'({sda_oe, sda_o}), 3);
    if (stray) begin
      seen = 0;
      repeat (4) begin
        m_sck = 1; repeat (HALF) tick();
        m_sck = 0; repeat (HALF) tick();
      end
      repeat (8) tick();
      check(!seen, "R8 no strobe on busy edges", int'(seen), 0);
      check(sda_oe && sda_o, "R8 line still high", int'({sda_oe, sda_o}), 3);
    end
    repeat (20) tick();
    check(sda_oe && sda_o, "R3 busy held", int'({sda_oe, sda_o}), 3);
    rsp_data = r; rsp_valid = 1;
    tick();
    rsp_valid = 0;
    bad = 0;
    for (int i = 0; i < RC; i++) begin
      if (!(sda_oe && !sda_o)) bad++;
      tick();
    end
    check(bad == 0, "R5 low interval", bad, 0);
    check(sda_oe && sda_o == r[15], "R5 first bit after low", int'({sda_oe, sda_o}), int'({1'b1, r[15]}));
    got = '0;
    for (int i = 15; i >= 0; i--) begin
      repeat (HALF) tick();
      got[i] = sda_oe ? sda_o : 1'b0;
      m_sck = 1;
      repeat (HALF) tick();
      m_sck = 0;
    end
    repeat (8) tick();
    check(got == r, "R6 response word", int'(got), int'(r));
    check(!sda_oe, "R7 line released", int'(sda_oe), 0);
  endtask

  initial begin
    repeat (4) tick();
    check(!sda_oe && !cmd_valid && cmd_data == 0, "R1 reset state",
          int'({sda_oe, cmd_valid, cmd_data}), 0);
    rst_n = 1;
    repeat (4) tick();
    check(!sda_oe && !cmd_valid, "R1 after release", int'({sda_oe, cmd_valid}), 0);
    rsp_data = 16'hDEAD; rsp_valid = 1;
    tick();
    rsp_valid = 0;
    repeat (6) tick();
    check(!sda_oe, "R4 rsp ignored in receive", int'(sda_oe), 0);
    transact(16'hA5C3, 16'h8001, 1);
    transact(16'h0001, 16'h1234, 0);
    transact(16'hFFFF, 16'hFFFF, 1);
    transact(16'h0000, 16'h0000, 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule